// File: doc/BRIEF.md
# Two-Channel Double-Buffered Converter Register Front End

This block is the digital front end of a two-channel parallel-input converter. A 16-bit data word, a two-bit channel address and two strobes (an active-low write strobe and an active-high load strobe) move codes through two register stages per channel. The first stage is a holding register. The second stage is the code register that drives the converter. The address picks channel A, channel B, both channels or neither. The strobe levels decide whether the holding stage captures, the code stage transfers, both stages pass the bus straight through, or nothing changes.

An active-low clear input forces all four registers to a reset code. A select input chooses that code: zero scale or midscale. The clear is applied as soon as the input falls, and its release is synchronised to the clock. The strobes are level-sensitive and are sampled on each rising clock edge. Each channel's code register is split into a 4-bit upper part and a 12-bit lower part. The upper part is presented as a 15-line thermometer word and the lower part as plain binary. A one-cycle flag marks every cycle in which a code register has just changed.

Top module: `twin_dac_front`

## Requirements
- R1: The address `addr` selects the channels that a strobe acts on: 2'b00 channel A only, 2'b11 channel B only, 2'b10 both channels, 2'b01 none. A channel that is not selected keeps both of its registers.
- R2: While `clr_n` is low, every rising edge loads the reset code into the holding and code registers of both channels, whatever the levels of the strobes and the address.
- R3: The reset code is 16'h0000 when `mid_sel` is 0 and 16'h8000 when it is 1. `mid_sel` is read continuously: changing it outside reset leaves the registers alone, and the next reset uses the new value.
- R4: `wr_n`=0 with `ld`=0 loads `din` into the selected holding registers; the code registers hold.
- R5: `wr_n`=1 with `ld`=1 copies each selected holding register into its code register.
- R6: `wr_n`=0 with `ld`=1 makes both stages transparent: the selected holding and code registers both take `din`.
- R7: `wr_n`=1 with `ld`=0 changes no register.
- R8: When `wr_n` and `ld` are driven as one signal, a low phase captures `din` into the holding register without touching the code register, and the following high phase moves it into the code register.
- R9: For each channel, `seg_x[i]` is 1 exactly when the upper 4 bits of the code register exceed i (i = 0..14), so a value k lights k lines. `lsb_x` equals the lower 12 bits of the code register.
- R10: `upd` is 1 for the one cycle after a rising edge outside reset that changed either code register, and 0 otherwise, including throughout reset.
- R11: After `clr_n` rises, the first two rising edges still apply the reset code. Strobes take effect from the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the surrounding logic |
| clr_n | input | 1 | Active-low clear; asserted at once, released through a synchroniser |
| mid_sel | input | 1 | Reset code select: 0 zero scale, 1 midscale |
| wr_n | input | 1 | Active-low write strobe (level) |
| ld | input | 1 | Active-high load strobe (level) |
| addr | input | 2 | Channel address |
| din | input | 16 | Parallel data word |
| seg_a | output | 15 | Channel A thermometer lines for the upper 4 code bits |
| lsb_a | output | 12 | Channel A lower 12 code bits |
| seg_b | output | 15 | Channel B thermometer lines for the upper 4 code bits |
| lsb_b | output | 12 | Channel B lower 12 code bits |
| upd | output | 1 | One-cycle flag: a code register has just changed |

## Verification
On every cycle, assertions check the following:
- For each strobe level pair and channel select, the effect on the holding and code registers in the next cycle.
- That reset forces the selected reset code.
- That the thermometer line count matches the upper code bits.
- That `upd` rises exactly when a code register has changed outside reset.

The holding register has no output of its own, so only the bench scenarios can show its contents: each write is followed by a load that brings the holding register out through the code outputs. The bench scenarios also cover:
- the two-edge hold-off after the clear is released;
- a change of `mid_sel` outside reset taking effect only at the next reset;
- the tied-strobe pulse;
- the full sweep of strobe pairs, addresses and reset codes.

// File: rtl/dacfe_pkg.sv
// Package: shared types and the thermometer helper for the converter front end.
// Assumes: address coding is fixed by the channel-select behaviour.
package dacfe_pkg;

    typedef enum logic [1:0] {
        ADDR_CH_A  = 2'b00,
        ADDR_NONE  = 2'b01,
        ADDR_BOTH  = 2'b10,
        ADDR_CH_B  = 2'b11
    } chan_addr_e;

    // Strobe pair {wr_n, ld} as an operation
    typedef enum logic [1:0] {
        OP_CAPTURE = 2'b00,
        OP_THROUGH = 2'b01,
        OP_IDLE    = 2'b10,
        OP_TRANSFER = 2'b11
    } strobe_op_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/dacfe_rst_sync.sv
// Module: clear synchroniser. The clear is asserted as soon as clr_n falls and is
// released only after STAGES rising edges with clr_n high.
// Assumes: clr_n may change at any time relative to clk.
module dacfe_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic rst_s_n
);

    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear the chain immediately on assertion
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_s_n = chain_q[STAGES-1];

endmodule

// File: rtl/dacfe_addr_dec.sv
// Module: channel address decoder. Turns the two-bit address into one select
// line per channel (index 0 = channel A, index 1 = channel B).
// Assumes: the "none" code selects nothing and the "both" code selects every channel.
module dacfe_addr_dec
    import dacfe_pkg::*;
(
    input  logic [1:0]        addr,
    output logic [NUM_CH-1:0] sel
);

    // Map each address code onto the channel select lines
    always_comb begin
        unique case (chan_addr_e'(addr))
            ADDR_CH_A: sel = 2'b01;
            ADDR_CH_B: sel = 2'b10;
            ADDR_BOTH: sel = 2'b11;
            default:   sel = 2'b00;
        endcase
    end

    // R1: never more than one channel unless the both code is applied
    always_comb begin
        a_r1_single_select: assert (addr == ADDR_BOTH || $onehot0(sel));
    end

endmodule

// File: rtl/dacfe_channel.sv
// Module: one channel's holding and code registers. The strobe pair is read as a level
// on each rising edge; a deselected channel holds. The reset code is loaded while the
// synchronised reset is low (synchronous active-low reset).
// Assumes: rst_val is stable for at least the edge on which it is used.
module dacfe_channel
    import dacfe_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_s_n,
    input  logic [DATA_W-1:0] rst_val,
    input  logic              sel,
    input  logic              wr_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] hold_q,
    output logic [DATA_W-1:0] code_q,
    output logic              code_chg
);

    logic [DATA_W-1:0] hold_d;
    logic [DATA_W-1:0] code_d;

    // Next-state selection from the strobe operation
    always_comb begin
        hold_d = hold_q;
        code_d = code_q;
        if (sel) begin
            unique case (strobe_op_e'({wr_n, ld}))
                OP_CAPTURE:  hold_d = din;
                OP_THROUGH: begin
                    hold_d = din;
                    code_d = din;
                end
                OP_TRANSFER: code_d = hold_q;
                default: ;
            endcase
        end
    end

    // Register update with synchronous reset to the selected reset code
    always_ff @(posedge clk) begin
        if (!rst_s_n) begin
            hold_q <= rst_val;
            code_q <= rst_val;
        end else begin
            hold_q <= hold_d;
            code_q <= code_d;
        end
    end

    // Flags a code change that the next edge will make outside reset
    assign code_chg = rst_s_n && (code_d != code_q);

    // R2 / R3: reset loads the selected code into both stages
    a_r2_reset_load: assert property (@(posedge clk)
        !rst_s_n |=> (hold_q == $past(rst_val)) && (code_q == $past(rst_val)));

    // R1: a deselected channel holds
    a_r1_deselected_holds: assert property (@(posedge clk) disable iff (!rst_s_n)
        !sel |=> $stable(hold_q) && $stable(code_q));

    // R4: capture loads the holding stage only
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_s_n)
        (sel && !wr_n && !ld) |=> (hold_q == $past(din)) && $stable(code_q));

    // R5: transfer copies holding into code
    a_r5_transfer: assert property (@(posedge clk) disable iff (!rst_s_n)
        (sel && wr_n && ld) |=> (code_q == $past(hold_q)) && $stable(hold_q));

    // R6: transparent mode passes the bus to both stages
    a_r6_through: assert property (@(posedge clk) disable iff (!rst_s_n)
        (sel && !wr_n && ld) |=> (code_q == $past(din)) && (hold_q == $past(din)));

    // R7: idle strobes change nothing
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
        (wr_n && !ld) |=> $stable(hold_q) && $stable(code_q));

endmodule

// File: rtl/dacfe_therm.sv
// Module: code splitter. Upper SEG_BITS of the code become a thermometer word of
// 2**SEG_BITS-1 equally weighted lines; the remaining low bits pass through.
// Assumes: DATA_W > SEG_BITS.
module dacfe_therm #(
    parameter int DATA_W   = 16,
    parameter int SEG_BITS = 4,
    localparam int SEG_N   = (1 << SEG_BITS) - 1,
    localparam int LSB_W   = DATA_W - SEG_BITS
) (
    input  logic [DATA_W-1:0] code,
    output logic [SEG_N-1:0]  seg,
    output logic [LSB_W-1:0]  lsb
);

    logic [SEG_BITS-1:0] top;
    assign top = code[DATA_W-1 -: SEG_BITS];
    assign lsb = code[LSB_W-1:0];

    // One comparator per thermometer line
    for (genvar i = 0; i < SEG_N; i++) begin : g_line
        assign seg[i] = (top > SEG_BITS'(i));
    end

    // R9: the number of lit lines equals the upper code value
    always_comb begin
        a_r9_line_count: assert ($countones(seg) == int'(top));
    end

endmodule

// File: rtl/twin_dac_front.sv
// Module: top of the two-channel double-buffered converter front end. Synchronises
// the clear, decodes the channel address, holds two channels of registers and splits
// each code into thermometer and binary parts; flags code changes for one cycle.
// Assumes: all strobes are in the clk domain; clr_n may be asynchronous.
module twin_dac_front
    import dacfe_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SEG_BITS  = 4,
    parameter int RST_STAGES = 2,
    localparam int SEG_N    = (1 << SEG_BITS) - 1,
    localparam int LSB_W    = DATA_W - SEG_BITS
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              mid_sel,
    input  logic              wr_n,
    input  logic              ld,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] din,
    output logic [SEG_N-1:0]  seg_a,
    output logic [LSB_W-1:0]  lsb_a,
    output logic [SEG_N-1:0]  seg_b,
    output logic [LSB_W-1:0]  lsb_b,
    output logic              upd
);

    localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

    logic              rst_s_n;
    logic [DATA_W-1:0] rst_val;
    logic [NUM_CH-1:0] sel;
    logic [DATA_W-1:0] hold_q [NUM_CH];
    logic [DATA_W-1:0] code_q [NUM_CH];
    logic [NUM_CH-1:0] chg;
    logic [SEG_N-1:0]  seg_w  [NUM_CH];
    logic [LSB_W-1:0]  lsb_w  [NUM_CH];

    dacfe_rst_sync #(.STAGES(RST_STAGES)) u_rst (
        .clk     (clk),
        .clr_n   (clr_n),
        .rst_s_n (rst_s_n)
    );

    // Reset code follows the select input continuously
    assign rst_val = mid_sel ? MID_CODE : '0;

    dacfe_addr_dec u_dec (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dacfe_channel #(.DATA_W(DATA_W)) u_ch (
            .clk      (clk),
            .rst_s_n  (rst_s_n),
            .rst_val  (rst_val),
            .sel      (sel[c]),
            .wr_n     (wr_n),
            .ld       (ld),
            .din      (din),
            .hold_q   (hold_q[c]),
            .code_q   (code_q[c]),
            .code_chg (chg[c])
        );

        dacfe_therm #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) u_split (
            .code (code_q[c]),
            .seg  (seg_w[c]),
            .lsb  (lsb_w[c])
        );
    end

    assign seg_a = seg_w[0];
    assign lsb_a = lsb_w[0];
    assign seg_b = seg_w[1];
    assign lsb_b = lsb_w[1];

    // Change flag: one cycle after an edge that altered a code register
    always_ff @(posedge clk) begin
        if (!rst_s_n) begin
            upd <= 1'b0;
        end else begin
            upd <= |chg;
        end
    end

    // R10: a flag always reflects a real change
    a_r10_flag_real: assert property (@(posedge clk) disable iff (!rst_s_n)
        upd |-> (code_q[0] != $past(code_q[0])) || (code_q[1] != $past(code_q[1])));

    // R10: every change made outside reset is flagged
    a_r10_change_flagged: assert property (@(posedge clk) disable iff (!rst_s_n)
        (((code_q[0] != $past(code_q[0])) || (code_q[1] != $past(code_q[1])))
         && $past(rst_s_n)) |-> upd);

endmodule

// File: tb/twin_dac_front_test.sv
// Bench: directed scenarios against a requirement-level model of both channels.
module twin_dac_front_test;

    logic        clk = 1'b0;
    logic        clr_n = 1'b0;
    logic        mid_sel = 1'b0;
    logic        wr_n = 1'b1;
    logic        ld = 1'b0;
    logic [1:0]  addr = 2'b01;
    logic [15:0] din = '0;
    logic [14:0] seg_a, seg_b;
    logic [11:0] lsb_a, lsb_b;
    logic        upd;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_hold [2];
    logic [15:0] m_code [2];
    logic        m_upd;

    twin_dac_front uut (
        .clk(clk), .clr_n(clr_n), .mid_sel(mid_sel), .wr_n(wr_n), .ld(ld),
        .addr(addr), .din(din), .seg_a(seg_a), .lsb_a(lsb_a),
        .seg_b(seg_b), .lsb_b(lsb_b), .upd(upd)
    );

    always #4 clk = ~clk;

    // Compare both channels' outputs and the flag with the model (R9, R10)
    task automatic compare(input string tag);
        for (int c = 0; c < 2; c++) begin
            logic [14:0] exp_seg;
            logic [14:0] got_seg;
            logic [11:0] got_lsb;
            for (int i = 0; i < 15; i++) exp_seg[i] = (m_code[c][15:12] > 4'(i));
            got_seg = (c == 0) ? seg_a : seg_b;
            got_lsb = (c == 0) ? lsb_a : lsb_b;
            checks++;
            if (got_seg !== exp_seg || got_lsb !== m_code[c][11:0]) begin
                errors++;
                $display("FAIL %s R9 ch%0d: seg=%h lsb=%h expected seg=%h lsb=%h",
                         tag, c, got_seg, got_lsb, exp_seg, m_code[c][11:0]);
            end
        end
        checks++;
        if (upd !== m_upd) begin
            errors++;
            $display("FAIL %s R10 flag: got %b expected %b", tag, upd, m_upd);
        end
    endtask

    // One clocked step with strobes held; model follows R1 and R4-R7
    task automatic step(input logic w, input logic l, input logic [1:0] a,
                        input logic [15:0] d, input string tag);
        logic [1:0] s;
        logic [15:0] old0, old1;
        @(negedge clk);
        wr_n = w; ld = l; addr = a; din = d;
        @(posedge clk);
        s = (a == 2'b00) ? 2'b01 : (a == 2'b11) ? 2'b10 : (a == 2'b10) ? 2'b11 : 2'b00;
        old0 = m_code[0]; old1 = m_code[1];
        for (int c = 0; c < 2; c++) begin
            if (s[c]) begin
                case ({w, l})
                    2'b00: m_hold[c] = d;
                    2'b01: begin m_hold[c] = d; m_code[c] = d; end
                    2'b11: m_code[c] = m_hold[c];
                    default: ;
                endcase
            end
        end
        m_upd = (old0 != m_code[0]) || (old1 != m_code[1]);
        #1;
        compare(tag);
    endtask

    // Clear with strobes active, then release and check the hold-off (R2, R3, R11)
    task automatic do_reset(input logic mid);
        logic [15:0] rv;
        rv = mid ? 16'h8000 : 16'h0000;
        @(negedge clk);
        clr_n = 1'b0; mid_sel = mid; wr_n = 1'b0; ld = 1'b1; addr = 2'b10; din = 16'h1234;
        repeat (2) @(posedge clk);
        #1;
        for (int c = 0; c < 2; c++) begin m_hold[c] = rv; m_code[c] = rv; end
        m_upd = 1'b0;
        compare("R2/R3 reset");
        @(negedge clk);
        clr_n = 1'b1; din = 16'h5A5A;
        repeat (2) begin
            @(posedge clk); #1;
            compare("R11 hold-off");
        end
        @(posedge clk); #1;
        for (int c = 0; c < 2; c++) begin m_hold[c] = 16'h5A5A; m_code[c] = 16'h5A5A; end
        m_upd = (rv != 16'h5A5A);
        compare("R11 first active edge");
        step(1'b1, 1'b0, 2'b01, 16'h0, "R7 idle after reset");
    endtask

    // R2 / R3: both reset codes
    task automatic t_reset_codes();
        do_reset(1'b0);
        do_reset(1'b1);
    endtask

    // R3: select change outside reset has no effect until the next reset
    task automatic t_mid_sel_live();
        do_reset(1'b0);
        step(1'b0, 1'b1, 2'b10, 16'h0000, "R3 set zero");
        @(negedge clk); mid_sel = 1'b1;
        step(1'b1, 1'b0, 2'b00, 16'hFFFF, "R3 select change ignored");
        do_reset(1'b1);
    endtask

    // R1, R4-R7: every strobe pair against every address, for both reset codes
    task automatic t_matrix();
        for (int mid = 0; mid < 2; mid++) begin
            for (int a = 0; a < 4; a++) begin
                for (int op = 0; op < 4; op++) begin
                    logic [15:0] d;
                    d = 16'hC3E7 ^ 16'(a * 16'h1111) ^ 16'(op * 16'h0F0F);
                    do_reset(1'(mid));
                    step(1'b0, 1'b1, 2'b00, 16'h2AB1, "R6 preload A");
                    step(1'b0, 1'b1, 2'b11, 16'hE47C, "R6 preload B");
                    step(1'(op >> 1), 1'(op), 2'(a), d, "R1/R4/R5/R6/R7 op");
                    step(1'b1, 1'b1, 2'b10, 16'h0, "R5 reveal holding");
                end
            end
        end
    endtask

    // R8: strobes tied together as one pulse
    task automatic t_tied_pulse();
        step(1'b0, 1'b0, 2'b11, 16'h9C3D, "R8 pulse low phase");
        step(1'b1, 1'b1, 2'b11, 16'h0001, "R8 pulse high phase");
        step(1'b0, 1'b0, 2'b10, 16'h7001, "R8 both low phase");
        step(1'b1, 1'b1, 2'b10, 16'h0, "R8 both high phase");
    endtask

    // R9: all sixteen upper-nibble values
    task automatic t_segments();
        for (int k = 0; k < 16; k++) begin
            step(1'b0, 1'b1, 2'b00, {4'(k), 12'hA5C ^ 12'(k)}, "R9 sweep A");
            step(1'b0, 1'b1, 2'b11, {4'(15 - k), 12'(k * 7)}, "R9 sweep B");
        end
    endtask

    // R10: flag stays low when a write leaves the code unchanged
    task automatic t_flag();
        step(1'b0, 1'b1, 2'b10, 16'h4321, "R10 change");
        step(1'b0, 1'b1, 2'b10, 16'h4321, "R10 same value");
        step(1'b1, 1'b1, 2'b10, 16'h0, "R10 transfer same");
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin m_hold[c] = '0; m_code[c] = '0; end
        m_upd = 1'b0;
        t_reset_codes();
        t_mid_sel_live();
        t_matrix();
        t_tied_pulse();
        t_segments();
        t_flag();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule